// File: doc/BRIEF.md
# Delayed-Branch Resume Address Resolver

This block serves a trap handler that must emulate one faulting instruction of a 16-bit instruction set and then resume execution. The handler presents the word at the trapping PC, together with the PC, the T condition bit, the procedure-return register and a general-register value. The block classifies the word as one of the delayed-branch forms or as an ordinary instruction. It then works out where execution resumes, whether the instruction to emulate sits in the delay slot at PC+2, and whether the return register must be loaded with a return address.

The register operand index is taken straight from the word's second nibble (bits 11:8) and is driven back out without a register stage. The register file can therefore return the operand in the same cycle. All other results are captured one clock after a valid request. They hold their value until the next valid request. Address arithmetic is 32-bit and wraps modulo 2^32.

Top module: `nextpc_resolver`

## Requirements
- R1: While `rst` is high, and after it falls until the first accepted request, `out_valid`, `out_next_pc`, `out_slot_addr`, `out_fetch_slot`, `out_emul_word`, `out_pr_we`, `out_pr_data` and `out_class` are all zero.
- R2: `rn_idx` always equals bits 11:8 of `insn`, with no clock delay.
- R3: Top nibble 0xA (class BRA) or 0xB (class BSR) gives next PC = PC + 4 + (sign-extended bits 11:0) × 2.
- R4: BSR and the register-indirect call 0x4n0B (class JSR) assert `out_pr_we` with `out_pr_data` = PC + 4. Every other word leaves `out_pr_we` and `out_pr_data` at zero.
- R5: High byte 0x8D (class BTS) branches to PC + 4 + (sign-extended bits 7:0) × 2 when T = 1 and goes to PC + 4 when T = 0. High byte 0x8F (class BFS) does the same with the T condition reversed.
- R6: Words 0x4n0B (JSR) and 0x4n2B (JMP) give next PC = Rn.
- R7: Words 0x0n23 (BRAF) and 0x0n03 (BSRF) give next PC = PC + 4 + Rn, and neither asserts the PR write.
- R8: Exactly 0x000B (class RTS) gives next PC = PR. A word such as 0x010B is ordinary.
- R9: Every other word (class NONE) gives next PC = PC + 2, `out_fetch_slot` = 0 and `out_emul_word` = `insn`.
- R10: For every branch class, `out_fetch_slot` = 1, `out_slot_addr` = PC + 2 and `out_emul_word` = 0. `out_slot_addr` is PC + 2 for every class.
- R11: `out_class` encoding: 0 NONE, 1 BRA, 2 BSR, 3 BTS, 4 BFS, 5 JMP, 6 JSR, 7 BRAF, 8 BSRF, 9 RTS.
- R12: All sums wrap modulo 2^32.
- R13: Results appear on the clock edge after `in_valid` is high, with `out_valid` high for that one cycle. Without `in_valid`, the results hold and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insn | input | 16 | Instruction word at the trapping PC |
| pc | input | 32 | Trapping PC |
| t_bit | input | 1 | T condition flag |
| pr_val | input | 32 | Procedure-return register value |
| rn_val | input | 32 | Register-file value at `rn_idx` |
| rn_idx | output | 4 | Register index for the Rn read |
| out_valid | output | 1 | Results updated this cycle |
| out_class | output | 4 | Branch class code |
| out_next_pc | output | 32 | Resume address |
| out_slot_addr | output | 32 | Address of the delay-slot halfword |
| out_fetch_slot | output | 1 | Emulated word must be fetched from the slot address |
| out_emul_word | output | 16 | Word to emulate when no fetch is needed |
| out_pr_we | output | 1 | PR must be written |
| out_pr_data | output | 32 | Value for PR |

## Verification
Directed words cover each branch form with positive and negative displacements. Both T values are applied to each conditional branch, which shows whether the condition is reversed between BTS and BFS. Near-miss encodings (0x4n1B, 0x0n13, 0x010B, 0x8E) must fall to class NONE, which shows whether the decoder compares every required nibble. PCs and register values near 0xFFFFFFFF test the wrapping arithmetic. Several thousand words with a biased top nibble are then compared on every clock against a behavioural model. Idle cycles between those words show that the outputs hold.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int INSN_W = 16;
  localparam int CLS_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    BC_NONE = 4'd0,
    BC_BRA  = 4'd1,
    BC_BSR  = 4'd2,
    BC_BTS  = 4'd3,
    BC_BFS  = 4'd4,
    BC_JMP  = 4'd5,
    BC_JSR  = 4'd6,
    BC_BRAF = 4'd7,
    BC_BSRF = 4'd8,
    BC_RTS  = 4'd9
  } br_class_t;
endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output br_class_t         cls
);
  logic [3:0] nb0, nb1, nb2, nb3;

  assign nb0 = insn[15:12];
  assign nb1 = insn[11:8];
  assign nb2 = insn[7:4];
  assign nb3 = insn[3:0];

  // The patterns are disjoint, so the order of the tests only affects layout.
  always_comb begin
    cls = BC_NONE;
    if (nb0 == 4'hA) begin
      cls = BC_BRA;
    end else if (nb0 == 4'hB) begin
      cls = BC_BSR;
    end else if (nb0 == 4'h8 && nb1 == 4'hD) begin
      cls = BC_BTS;
    end else if (nb0 == 4'h8 && nb1 == 4'hF) begin
      cls = BC_BFS;
    end else if (nb0 == 4'h4 && nb3 == 4'hB && nb2 == 4'h0) begin
      cls = BC_JSR;
    end else if (nb0 == 4'h4 && nb3 == 4'hB && nb2 == 4'h2) begin
      cls = BC_JMP;
    end else if (nb0 == 4'h0 && nb3 == 4'h3 && nb2 == 4'h0) begin
      cls = BC_BSRF;
    end else if (nb0 == 4'h0 && nb3 == 4'h3 && nb2 == 4'h2) begin
      cls = BC_BRAF;
    end else if (insn == 16'h000B) begin
      cls = BC_RTS;
    end
  end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int AW = 32
) (
  input  br_class_t   cls,
  input  logic [11:0] disp,
  input  logic [AW-1:0] pc,
  input  logic        t_bit,
  input  logic [AW-1:0] pr_val,
  input  logic [AW-1:0] rn_val,
  output logic [AW-1:0] next_pc,
  output logic        pr_we,
  output logic [AW-1:0] pr_data,
  output logic        fetch_slot
);
  localparam int D12_EXT = AW - 13;
  localparam int D8_EXT  = AW - 9;

  logic [AW-1:0] pc_p2, pc_p4, off12, off8;

  assign pc_p2 = pc + AW'(2);
  assign pc_p4 = pc + AW'(4);
  assign off12 = {{D12_EXT{disp[11]}}, disp[11:0], 1'b0};
  assign off8  = {{D8_EXT{disp[7]}}, disp[7:0], 1'b0};

  always_comb begin
    next_pc    = pc_p2;
    pr_we      = 1'b0;
    pr_data    = '0;
    fetch_slot = 1'b1;
    case (cls)
      BC_BRA:  next_pc = pc_p4 + off12;
      BC_BSR: begin
        next_pc = pc_p4 + off12;
        pr_we   = 1'b1;
        pr_data = pc_p4;
      end
      BC_BTS:  next_pc = t_bit ? (pc_p4 + off8) : pc_p4;
      BC_BFS:  next_pc = t_bit ? pc_p4 : (pc_p4 + off8);
      BC_JMP:  next_pc = rn_val;
      BC_JSR: begin
        next_pc = rn_val;
        pr_we   = 1'b1;
        pr_data = pc_p4;
      end
      BC_BRAF, BC_BSRF: next_pc = pc_p4 + rn_val;
      BC_RTS:  next_pc = pr_val;
      default: fetch_slot = 1'b0;
    endcase
  end
endmodule

// File: rtl/nextpc_resolver.sv
module nextpc_resolver
  import nextpc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] pc,
  input  logic          t_bit,
  input  logic [AW-1:0] pr_val,
  input  logic [AW-1:0] rn_val,
  output logic [3:0]    rn_idx,
  output logic          out_valid,
  output logic [3:0]    out_class,
  output logic [AW-1:0] out_next_pc,
  output logic [AW-1:0] out_slot_addr,
  output logic          out_fetch_slot,
  output logic [15:0]   out_emul_word,
  output logic          out_pr_we,
  output logic [AW-1:0] out_pr_data
);
  br_class_t     cls;
  logic [AW-1:0] nx_pc, nx_pr_data, slot_addr;
  logic          nx_pr_we, nx_fetch;

  assign rn_idx    = insn[11:8];
  assign slot_addr = pc + AW'(2);

  nextpc_decode u_decode (
    .insn (insn),
    .cls  (cls)
  );

  nextpc_target #(.AW(AW)) u_target (
    .cls        (cls),
    .disp       (insn[11:0]),
    .pc         (pc),
    .t_bit      (t_bit),
    .pr_val     (pr_val),
    .rn_val     (rn_val),
    .next_pc    (nx_pc),
    .pr_we      (nx_pr_we),
    .pr_data    (nx_pr_data),
    .fetch_slot (nx_fetch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_class      <= '0;
      out_next_pc    <= '0;
      out_slot_addr  <= '0;
      out_fetch_slot <= 1'b0;
      out_emul_word  <= '0;
      out_pr_we      <= 1'b0;
      out_pr_data    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_class      <= cls;
        out_next_pc    <= nx_pc;
        out_slot_addr  <= slot_addr;
        out_fetch_slot <= nx_fetch;
        out_emul_word  <= nx_fetch ? 16'h0000 : insn;
        out_pr_we      <= nx_pr_we;
        out_pr_data    <= nx_pr_data;
      end
    end
  end

  // R10: the fetch flag agrees with the class from the decoder
  assert_slot_flag_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_fetch_slot == (out_class != 4'd0)));

  // R4: a PR write only happens for the two call forms
  assert_pr_class_R4: assert property (@(posedge clk) disable iff (rst)
    out_pr_we |-> (out_class == 4'd2 || out_class == 4'd6));

  // R4: the return value is two halfwords past the slot address
  assert_pr_data_R4: assert property (@(posedge clk) disable iff (rst)
    out_pr_we |-> (out_pr_data == out_slot_addr + AW'(2)));

  // R9: ordinary words resume at the slot address and never touch PR
  assert_plain_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 4'd0) |-> (out_next_pc == out_slot_addr && !out_pr_we));

  // R13: a request yields a valid result on the next edge
  assert_valid_R13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> out_valid);

  // R13: results hold while no request is present
  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !rst) |=> (!out_valid && $stable(out_next_pc) && $stable(out_class)));
endmodule

// File: tb/test_nextpc_resolver.sv
module test_nextpc_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] insn = 16'h0;
  logic [31:0] pc = 32'h0;
  logic        t_bit = 1'b0;
  logic [31:0] pr_val = 32'h0;
  logic [31:0] rn_val = 32'h0;
  logic [3:0]  rn_idx;
  logic        out_valid;
  logic [3:0]  out_class;
  logic [31:0] out_next_pc, out_slot_addr, out_pr_data;
  logic        out_fetch_slot, out_pr_we;
  logic [15:0] out_emul_word;

  int total = 0;
  int bad = 0;

  // expected state of the outputs
  logic        e_valid = 0;
  logic [3:0]  e_class = 0;
  logic [31:0] e_next = 0, e_slot = 0, e_prd = 0;
  logic        e_fetch = 0, e_prwe = 0;
  logic [15:0] e_word = 0;
  string       e_tag = "R1";

  always #5 clk = ~clk;

  nextpc_resolver i_nextpc_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .pc(pc),
    .t_bit(t_bit), .pr_val(pr_val), .rn_val(rn_val), .rn_idx(rn_idx),
    .out_valid(out_valid), .out_class(out_class), .out_next_pc(out_next_pc),
    .out_slot_addr(out_slot_addr), .out_fetch_slot(out_fetch_slot),
    .out_emul_word(out_emul_word), .out_pr_we(out_pr_we), .out_pr_data(out_pr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (insn=%h pc=%h)", tag, act, exp, insn, pc);
    end
  endtask

  // behavioural reference: integer arithmetic on a 64-bit scratch, then wrapped (R12)
  task automatic model(input logic [15:0] w, input logic [31:0] p, input logic t,
                       input logic [31:0] prv, input logic [31:0] rn);
    longint base, d;
    int hi, n1, lo2, lo;
    hi = w[15:12]; n1 = w[11:8]; lo2 = w[7:4]; lo = w[3:0];
    base = longint'(p) + 4;
    e_class = 0; e_prwe = 0; e_prd = 0;
    e_next = 32'(longint'(p) + 2);
    e_tag = "R9";
    if (hi == 10 || hi == 11) begin
      d = longint'($signed(w[11:0])) * 2;
      e_next = 32'(base + d);
      e_class = (hi == 10) ? 4'd1 : 4'd2;
      e_tag = "R3";
      if (hi == 11) begin e_prwe = 1; e_prd = 32'(base); end
    end else if (hi == 8 && (n1 == 13 || n1 == 15)) begin
      d = longint'($signed(w[7:0])) * 2;
      if ((n1 == 13) == (t == 1'b1)) e_next = 32'(base + d);
      else e_next = 32'(base);
      e_class = (n1 == 13) ? 4'd3 : 4'd4;
      e_tag = "R5";
    end else if (hi == 4 && lo == 11 && (lo2 == 0 || lo2 == 2)) begin
      e_next = rn;
      e_class = (lo2 == 0) ? 4'd6 : 4'd5;
      e_tag = "R6";
      if (lo2 == 0) begin e_prwe = 1; e_prd = 32'(base); end
    end else if (hi == 0 && lo == 3 && (lo2 == 0 || lo2 == 2)) begin
      e_next = 32'(base + longint'(rn));
      e_class = (lo2 == 0) ? 4'd8 : 4'd7;
      e_tag = "R7";
    end else if (w == 16'h000B) begin
      e_next = prv;
      e_class = 4'd9;
      e_tag = "R8";
    end
    e_slot = 32'(longint'(p) + 2);
    e_fetch = (e_class != 0);
    e_word = e_fetch ? 16'h0 : w;
  endtask

  task automatic compare();
    chk(out_valid == e_valid, "R13 valid", 32'(out_valid), 32'(e_valid));
    chk(out_class == e_class, "R11 class", 32'(out_class), 32'(e_class));
    chk(out_next_pc == e_next, {e_tag, " next_pc"}, out_next_pc, e_next);
    chk(out_slot_addr == e_slot, "R10 slot", out_slot_addr, e_slot);
    chk(out_fetch_slot == e_fetch, "R10 fetch", 32'(out_fetch_slot), 32'(e_fetch));
    chk(out_emul_word == e_word, "R9 word", 32'(out_emul_word), 32'(e_word));
    chk(out_pr_we == e_prwe, "R4 pr_we", 32'(out_pr_we), 32'(e_prwe));
    chk(out_pr_data == e_prd, "R4 pr_data", out_pr_data, e_prd);
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input logic v, input logic [15:0] w, input logic [31:0] p,
                       input logic t, input logic [31:0] prv, input logic [31:0] rn);
    in_valid = v; insn = w; pc = p; t_bit = t; pr_val = prv; rn_val = rn;
    #1;
    chk(rn_idx == w[11:8], "R2 rn_idx", 32'(rn_idx), 32'(w[11:8]));
    if (v) model(w, p, t, prv, rn);
    e_valid = v;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    compare();
    rst = 1'b0;
    @(negedge clk);
    compare();

    apply(1, 16'hA005, 32'h0000_1000, 0, 32'h0, 32'h0);          // R3 bra forward
    apply(1, 16'hAFFF, 32'h0000_1000, 0, 32'h0, 32'h0);          // R3 bra back
    apply(1, 16'hB800, 32'h0000_2000, 0, 32'h0, 32'h0);          // R3/R4 bsr
    apply(1, 16'h8D10, 32'h0000_3000, 1, 32'h0, 32'h0);          // R5 bt/s taken
    apply(1, 16'h8D10, 32'h0000_3000, 0, 32'h0, 32'h0);          // R5 bt/s not taken
    apply(1, 16'h8FF0, 32'h0000_3000, 0, 32'h0, 32'h0);          // R5 bf/s taken
    apply(1, 16'h8FF0, 32'h0000_3000, 1, 32'h0, 32'h0);          // R5 bf/s not taken
    apply(1, 16'h430B, 32'h0000_4000, 0, 32'h0, 32'h1234_5678);  // R6 jsr, R4
    apply(1, 16'h452B, 32'h0000_4000, 0, 32'h0, 32'h8765_4320);  // R6 jmp
    apply(1, 16'h0723, 32'h0000_5000, 0, 32'h0, 32'h0000_0100);  // R7 braf
    apply(1, 16'h0303, 32'h0000_5000, 0, 32'h0, 32'hFFFF_FF00);  // R7 bsrf
    apply(1, 16'h000B, 32'h0000_6000, 0, 32'hCAFE_0000, 32'h0);  // R8 rts
    apply(1, 16'h010B, 32'h0000_6000, 0, 32'hCAFE_0000, 32'h0);  // R8 near miss
    apply(1, 16'h431B, 32'h0000_7000, 0, 32'h0, 32'h55);         // R9 near miss
    apply(1, 16'h0713, 32'h0000_7000, 0, 32'h0, 32'h55);         // R9 near miss
    apply(1, 16'h8E20, 32'h0000_7000, 1, 32'h0, 32'h55);         // R9 near miss
    apply(1, 16'hF00C, 32'h0000_7000, 0, 32'h0, 32'h0);          // R9 plain
    apply(1, 16'hF00C, 32'hFFFF_FFFE, 0, 32'h0, 32'h0);          // R12 wrap
    apply(1, 16'hA7FF, 32'hFFFF_FF00, 0, 32'h0, 32'h0);          // R12 wrap
    apply(1, 16'h0023, 32'hFFFF_FFF0, 0, 32'h0, 32'h0000_0020);  // R12 wrap
    apply(0, 16'hB123, 32'h0000_9000, 1, 32'h0, 32'h0);          // R13 hold
    apply(0, 16'h000B, 32'h0000_9000, 1, 32'h1, 32'h0);          // R13 hold

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      logic [3:0] sel;
      w = 16'($urandom);
      sel = 4'($urandom);
      case (sel)
        4'd0: w[15:12] = 4'hA;
        4'd1: w[15:12] = 4'hB;
        4'd2: w[15:8] = 8'h8D;
        4'd3: w[15:8] = 8'h8F;
        4'd4: begin w[15:12] = 4'h4; w[7:0] = ($urandom % 2) ? 8'h0B : 8'h2B; end
        4'd5: begin w[15:12] = 4'h0; w[7:0] = ($urandom % 2) ? 8'h03 : 8'h23; end
        4'd6: w = 16'h000B;
        default: ;
      endcase
      apply(($urandom % 4) != 0, w, $urandom, 1'($urandom), $urandom, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R13 watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule